// File: doc/BRIEF.md
# Serial Receiver with Hardware Address Filtering

This block is the receive half of an asynchronous serial port for multi-drop links. It takes a serial line and a 16x sample strobe from an external baud generator, and recovers bytes in one of four modes. Mode 0 is a shift-register mode with a fixed eight-bit frame. Mode 1 is an eight-bit frame with start and stop bits. Modes 2 and 3 are frames that carry a ninth data bit. The two nine-bit modes differ only in baud source, so they behave the same here. Each finished frame can load a receive buffer and raise a receive flag (`ri`). A missing stop bit raises a sticky framing-error flag.

When address filtering is on (`sm2` = 1), the flag is raised only for frames that carry an address the block answers to. A node therefore ignores traffic meant for other nodes without any software work. Two addresses are accepted. The given address is the address register with its masked-out bits ignored. The broadcast address is the OR of the address and the mask, with its zero bits ignored.

One control-bit slot (`ctl7`) is shared. Depending on `fe_sel`, software reads and writes either the framing-error flag or mode bit 0 through this slot. Mode bit 1 is an ordinary input.

Top module: `serial_rx_addrfilt`

## Requirements
- R1: After reset, `ri` = 0, `fe` = 0, `rx_byte` = 0 and mode bit 0 = 0, so `ctl7_rd` reads 0.
- R2: When `ctl7_we` = 1 and `fe_sel` = 1, `ctl7_wd` is written to the framing-error flag. When `ctl7_we` = 1 and `fe_sel` = 0, `ctl7_wd` is written to mode bit 0. A write to one never changes the other. `ctl7_rd` shows `fe` when `fe_sel` = 1 and mode bit 0 when `fe_sel` = 0.
- R3: The mode is {mode bit 0, `sm1`}. In mode 1 (2'b01) with `sm2` = 0, every frame behaves as follows: a low start bit, eight data bits sent LSB first, then a stop bit. The frame loads `rx_byte`, copies the stop bit into `rx_bit9` and sets `ri`.
- R4: A stop bit sampled as 0 sets `fe`. In mode 1 the stop bit is the bit after the eighth data bit; in modes 2 and 3 it is the bit after the ninth data bit. The flag stays set through later good frames. Only a software write through the R2 path clears it.
- R5: In modes 2 and 3 (2'b1x) with `sm2` = 1, a frame loads the buffer and sets `ri` only when its ninth bit is 1 and the byte hits the given or the broadcast address. Any other frame leaves `rx_byte` and `ri` unchanged. With `sm2` = 0, every nine-bit frame is accepted and its ninth bit is placed in `rx_bit9`.
- R6: In mode 1 with `sm2` = 1, a frame is accepted only when its stop bit is 1 and the byte hits the given or the broadcast address.
- R7: A byte hits the given address when it equals `saddr` on every bit where `saden` is 1. Bits where `saden` is 0 are ignored.
- R8: A byte hits the broadcast address when it is 1 on every bit where `saddr | saden` is 1.
- R9: Each bit is decided by a 2-of-3 majority vote over samples 7, 8 and 9 of its 16 strobe periods. A disturbance that lasts one strobe period does not change the received value.
- R10: A falling edge whose start bit votes high is treated as a false start. The receiver goes back to idle without touching `ri` and receives the next frame normally.
- R11: In mode 0 (2'b00), reception starts when `rx_en` = 1 and `ri` = 0. Eight bits are taken LSB first, one bit every 16 strobes, each decided as in R9. When the eighth bit arrives, the byte is loaded and `ri` is set. `sm2` is ignored in this mode.
- R12: A one-cycle pulse on `ri_clr` clears `ri`. A frame that completes in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | 16x oversampling strobe, one cycle wide |
| rxd | input | 1 | Serial line; idle level is high |
| sm1 | input | 1 | Mode bit 1 |
| sm2 | input | 1 | Enables address filtering |
| fe_sel | input | 1 | Selects whether the shared control bit is the framing-error flag (1) or mode bit 0 (0) |
| rx_en | input | 1 | Receive enable for mode 0 |
| saddr | input | 8 | Node address |
| saden | input | 8 | Address mask |
| ctl7_we | input | 1 | Write strobe for the shared control bit |
| ctl7_wd | input | 1 | Write data for the shared control bit |
| ri_clr | input | 1 | Clears `ri` |
| ctl7_rd | output | 1 | Read value of the shared control bit |
| rx_byte | output | 8 | Receive buffer |
| rx_bit9 | output | 1 | Ninth bit, or the stop bit in mode 1 |
| ri | output | 1 | Receive flag |
| fe | output | 1 | Sticky framing-error flag |

## Verification
A wrong bit index or a wrong vote tap shows up first in `rx_byte`, as a value shifted or corrupted in the first frame after the fault. `ri` goes wrong in the cycle after the stop-bit vote whenever the acceptance rule or the address match is wrong. The tests therefore pair hits against misses, and for each miss they confirm that the previous buffer is still in place. A fault in the shared control bit shows on `ctl7_rd` in the cycle after a write. A fault in the false-start path shows as a lost or garbled frame immediately after a short low pulse.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
  localparam logic [1:0] MODE_SHIFT = 2'b00;
  localparam logic [1:0] MODE_8BIT  = 2'b01;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_ASYNC = 2'b01,
    ST_SHIFT = 2'b10
  } rx_state_e;
endpackage

// File: rtl/rxaf_sync.sv
module rxaf_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = d_i;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= sync_d;
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/rxaf_sampler.sv
module rxaf_sampler #(
  parameter int unsigned OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic restart_i,
  input  logic rxd_i,
  output logic vote_valid_o,
  output logic vote_bit_o
);
  localparam int unsigned CW = $clog2(OVS);
  localparam logic [CW-1:0] TAP_A = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] TAP_B = CW'(OVS/2);
  localparam logic [CW-1:0] TAP_C = CW'(OVS/2 + 1);
  localparam logic [CW-1:0] LAST  = CW'(OVS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          smp_a_q, smp_a_d;
  logic          smp_b_q, smp_b_d;

  always_comb begin
    cnt_d   = cnt_q;
    smp_a_d = smp_a_q;
    smp_b_d = smp_b_q;
    if (restart_i) begin
      cnt_d = CW'(1);
    end else if (tick_i) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
      if (cnt_q == TAP_A) smp_a_d = rxd_i;
      if (cnt_q == TAP_B) smp_b_d = rxd_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      smp_a_q <= 1'b1;
      smp_b_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      smp_a_q <= smp_a_d;
      smp_b_q <= smp_b_d;
    end
  end

  assign vote_valid_o = tick_i && !restart_i && (cnt_q == TAP_C);
  assign vote_bit_o   = (smp_a_q & smp_b_q) | (smp_a_q & rxd_i) | (smp_b_q & rxd_i);

  // R9
  vote_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vote_valid_o |=> !vote_valid_o);
endmodule

// File: rtl/rxaf_addr_match.sv
module rxaf_addr_match #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] byte_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] mask_i,
  output logic          given_hit_o,
  output logic          bcast_hit_o
);
  logic [DW-1:0] bcast_bits;

  assign bcast_bits  = addr_i | mask_i;
  assign given_hit_o = ((byte_i ^ addr_i) & mask_i) == '0;
  assign bcast_hit_o = (byte_i & bcast_bits) == bcast_bits;

  // R7
  given_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_i == addr_i) |-> given_hit_o);
  // R8
  bcast_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&byte_i) |-> bcast_hit_o);
endmodule

// File: rtl/serial_rx_addrfilt.sv
module serial_rx_addrfilt #(
  parameter int unsigned DW   = 8,
  parameter int unsigned OVS  = 16,
  parameter int unsigned SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_tick,
  input  logic          rxd,
  input  logic          sm1,
  input  logic          sm2,
  input  logic          fe_sel,
  input  logic          rx_en,
  input  logic [DW-1:0] saddr,
  input  logic [DW-1:0] saden,
  input  logic          ctl7_we,
  input  logic          ctl7_wd,
  input  logic          ri_clr,
  output logic          ctl7_rd,
  output logic [DW-1:0] rx_byte,
  output logic          rx_bit9,
  output logic          ri,
  output logic          fe
);
  import rxaf_pkg::*;

  localparam int unsigned BW = $clog2(DW + 3);
  localparam logic [BW-1:0] IDX_LAST_DATA = BW'(DW);
  localparam logic [BW-1:0] IDX_STOP8     = BW'(DW + 1);
  localparam logic [BW-1:0] IDX_STOP9     = BW'(DW + 2);
  localparam logic [BW-1:0] IDX_SHIFT_END = BW'(DW - 1);

  rx_state_e     st_q, st_d;
  logic [BW-1:0] bidx_q, bidx_d;
  logic [DW-1:0] shreg_q, shreg_d;
  logic          b9_q, b9_d;
  logic          line_hi_q, line_hi_d;
  logic [DW-1:0] rbuf_q, rbuf_d;
  logic          rbit9_q, rbit9_d;
  logic          ri_q, ri_d;
  logic          fe_q, fe_d;
  logic          sm0_q, sm0_d;

  logic          rxd_s;
  logic          restart;
  logic          vote_valid, vote_bit;
  logic          given_hit, bcast_hit, addr_hit;
  logic          ri_set, fe_set;
  logic          last_bit;
  logic [1:0]    mode;
  logic [DW-1:0] sh_in;

  assign mode  = {sm0_q, sm1};
  assign sh_in = {vote_bit, shreg_q[DW-1:1]};

  rxaf_sync #(.STAGES(SYNC)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (rxd),
    .q_o   (rxd_s)
  );

  rxaf_sampler #(.OVS(OVS)) smp_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (sample_tick),
    .restart_i    (restart),
    .rxd_i        (rxd_s),
    .vote_valid_o (vote_valid),
    .vote_bit_o   (vote_bit)
  );

  rxaf_addr_match #(.DW(DW)) match_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_i      (shreg_q),
    .addr_i      (saddr),
    .mask_i      (saden),
    .given_hit_o (given_hit),
    .bcast_hit_o (bcast_hit)
  );

  assign addr_hit = given_hit | bcast_hit;
  assign last_bit = mode[1] ? (bidx_q == IDX_STOP9) : (bidx_q == IDX_STOP8);

  // frame sequencing
  always_comb begin
    st_d      = st_q;
    bidx_d    = bidx_q;
    shreg_d   = shreg_q;
    b9_d      = b9_q;
    line_hi_d = line_hi_q;
    rbuf_d    = rbuf_q;
    rbit9_d   = rbit9_q;
    restart   = 1'b0;
    ri_set    = 1'b0;
    fe_set    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (sample_tick) line_hi_d = rxd_s;
        if (mode == MODE_SHIFT) begin
          if (rx_en && !ri_q) begin
            st_d    = ST_SHIFT;
            bidx_d  = '0;
            restart = 1'b1;
          end
        end else if (sample_tick && line_hi_q && !rxd_s) begin
          st_d    = ST_ASYNC;
          bidx_d  = '0;
          restart = 1'b1;
        end
      end
      ST_ASYNC: begin
        if (vote_valid) begin
          bidx_d = bidx_q + BW'(1);
          if (bidx_q == '0) begin
            if (vote_bit) begin
              st_d      = ST_IDLE;
              line_hi_d = 1'b1;
            end
          end else if (bidx_q <= IDX_LAST_DATA) begin
            shreg_d = sh_in;
          end else if (!last_bit) begin
            b9_d = vote_bit;
          end else begin
            st_d      = ST_IDLE;
            line_hi_d = vote_bit;
            fe_set    = !vote_bit;
            if (mode[1]) begin
              if (!sm2 || (b9_q && addr_hit)) begin
                ri_set  = 1'b1;
                rbuf_d  = shreg_q;
                rbit9_d = b9_q;
              end
            end else begin
              if (!sm2 || (vote_bit && addr_hit)) begin
                ri_set  = 1'b1;
                rbuf_d  = shreg_q;
                rbit9_d = vote_bit;
              end
            end
          end
        end
      end
      ST_SHIFT: begin
        if (vote_valid) begin
          shreg_d = sh_in;
          bidx_d  = bidx_q + BW'(1);
          if (bidx_q == IDX_SHIFT_END) begin
            st_d   = ST_IDLE;
            ri_set = 1'b1;
            rbuf_d = sh_in;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // flags and shared control bit
  always_comb begin
    ri_d  = ri_set ? 1'b1 : (ri_clr ? 1'b0 : ri_q);
    fe_d  = fe_q;
    sm0_d = sm0_q;
    if (ctl7_we && fe_sel)  fe_d  = ctl7_wd;
    if (ctl7_we && !fe_sel) sm0_d = ctl7_wd;
    if (fe_set)             fe_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      bidx_q    <= '0;
      shreg_q   <= '0;
      b9_q      <= 1'b0;
      line_hi_q <= 1'b0;
      rbuf_q    <= '0;
      rbit9_q   <= 1'b0;
      ri_q      <= 1'b0;
      fe_q      <= 1'b0;
      sm0_q     <= 1'b0;
    end else begin
      st_q      <= st_d;
      bidx_q    <= bidx_d;
      shreg_q   <= shreg_d;
      b9_q      <= b9_d;
      line_hi_q <= line_hi_d;
      rbuf_q    <= rbuf_d;
      rbit9_q   <= rbit9_d;
      ri_q      <= ri_d;
      fe_q      <= fe_d;
      sm0_q     <= sm0_d;
    end
  end

  assign ctl7_rd = fe_sel ? fe_q : sm0_q;
  assign rx_byte = rbuf_q;
  assign rx_bit9 = rbit9_q;
  assign ri      = ri_q;
  assign fe      = fe_q;

  // R4
  fe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_q && !(ctl7_we && fe_sel)) |=> fe_q);
  // R5
  nine_bit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ri_q) && $past(mode[1] && sm2)) |-> rbit9_q);
  // R6
  stop_bit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ri_q) && $past(mode == MODE_8BIT && sm2)) |-> rbit9_q);
  // R12
  ri_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ri_clr && st_q == ST_IDLE) |=> !ri_q);
endmodule

// File: tb/serial_rx_addrfilt_tb_top.sv
module serial_rx_addrfilt_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_tick = 1'b0;
  logic       rxd = 1'b1;
  logic       sm1 = 1'b1;
  logic       sm2 = 1'b0;
  logic       fe_sel = 1'b0;
  logic       rx_en = 1'b0;
  logic [7:0] saddr = 8'h00;
  logic [7:0] saden = 8'h00;
  logic       ctl7_we = 1'b0;
  logic       ctl7_wd = 1'b0;
  logic       ri_clr = 1'b0;
  logic       ctl7_rd;
  logic [7:0] rx_byte;
  logic       rx_bit9;
  logic       ri;
  logic       fe;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) sample_tick <= 1'b0;
    else        sample_tick <= ~sample_tick;
  end

  serial_rx_addrfilt dut_i (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rxd(rxd),
    .sm1(sm1), .sm2(sm2), .fe_sel(fe_sel), .rx_en(rx_en),
    .saddr(saddr), .saden(saden), .ctl7_we(ctl7_we), .ctl7_wd(ctl7_wd),
    .ri_clr(ri_clr), .ctl7_rd(ctl7_rd), .rx_byte(rx_byte),
    .rx_bit9(rx_bit9), .ri(ri), .fe(fe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bit_time(input logic v);
    rxd = v;
    repeat (32) @(negedge clk);
  endtask

  task automatic send_async(input logic [7:0] d, input logic nine, input logic b9,
                            input logic stopv, input int glitch_bit);
    bit_time(1'b0);
    for (int i = 0; i < 8; i++) begin
      if (i == glitch_bit) begin
        rxd = d[i];
        repeat (15) @(negedge clk);
        rxd = ~d[i];
        repeat (2) @(negedge clk);
        rxd = d[i];
        repeat (15) @(negedge clk);
      end else begin
        bit_time(d[i]);
      end
    end
    if (nine) bit_time(b9);
    bit_time(stopv);
    bit_time(1'b1);
    bit_time(1'b1);
  endtask

  task automatic clear_ri();
    ri_clr = 1'b1;
    @(negedge clk);
    ri_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_ctl7(input logic sel, input logic wd);
    fe_sel  = sel;
    ctl7_wd = wd;
    ctl7_we = 1'b1;
    @(negedge clk);
    ctl7_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 ri after reset", ri, 0);
    check("R1 fe after reset", fe, 0);
    check("R1 rx_byte after reset", rx_byte, 8'h00);
    check("R1 ctl7_rd after reset", ctl7_rd, 0);
  endtask

  task automatic t_plain_8bit();
    sm1 = 1'b1; sm2 = 1'b0;
    send_async(8'hA5, 1'b0, 1'b0, 1'b1, -1);
    check("R3 byte", rx_byte, 8'hA5);
    check("R3 ri", ri, 1);
    check("R3 stop in bit9", rx_bit9, 1);
    check("R3 no fe", fe, 0);
    clear_ri();
    check("R12 ri cleared", ri, 0);
  endtask

  task automatic t_glitch();
    send_async(8'h3C, 1'b0, 1'b0, 1'b1, 2);
    check("R9 glitch byte", rx_byte, 8'h3C);
    check("R9 glitch ri", ri, 1);
    clear_ri();
  endtask

  task automatic t_false_start();
    rxd = 1'b0;
    repeat (8) @(negedge clk);
    bit_time(1'b1);
    bit_time(1'b1);
    check("R10 no ri on false start", ri, 0);
    send_async(8'h5A, 1'b0, 1'b0, 1'b1, -1);
    check("R10 next frame byte", rx_byte, 8'h5A);
    check("R10 next frame ri", ri, 1);
    clear_ri();
  endtask

  task automatic t_framing();
    send_async(8'h81, 1'b0, 1'b0, 1'b0, -1);
    check("R4 fe set", fe, 1);
    check("R4 frame still loaded", rx_byte, 8'h81);
    clear_ri();
    send_async(8'h11, 1'b0, 1'b0, 1'b1, -1);
    check("R4 fe sticky", fe, 1);
    clear_ri();
    fe_sel = 1'b1;
    @(negedge clk);
    check("R2 read fe via ctl7", ctl7_rd, 1);
    fe_sel = 1'b0;
    @(negedge clk);
    check("R2 read sm0 via ctl7", ctl7_rd, 0);
    write_ctl7(1'b1, 1'b0);
    check("R4 fe cleared by write", fe, 0);
  endtask

  task automatic t_addr_8bit();
    sm1 = 1'b1; sm2 = 1'b1; saddr = 8'h42; saden = 8'hFF;
    send_async(8'h42, 1'b0, 1'b0, 1'b1, -1);
    check("R6 given hit ri", ri, 1);
    check("R6 given hit byte", rx_byte, 8'h42);
    clear_ri();
    send_async(8'h43, 1'b0, 1'b0, 1'b1, -1);
    check("R6 miss ri", ri, 0);
    check("R6 miss keeps buffer", rx_byte, 8'h42);
    send_async(8'hFF, 1'b0, 1'b0, 1'b1, -1);
    check("R8 broadcast ri", ri, 1);
    check("R8 broadcast byte", rx_byte, 8'hFF);
    clear_ri();
    send_async(8'h42, 1'b0, 1'b0, 1'b0, -1);
    check("R6 bad stop ri", ri, 0);
    check("R6 bad stop keeps buffer", rx_byte, 8'hFF);
    check("R4 bad stop fe", fe, 1);
    write_ctl7(1'b1, 1'b0);
  endtask

  task automatic t_addr_9bit();
    write_ctl7(1'b0, 1'b1);
    check("R2 sm0 written", ctl7_rd, 1);
    check("R2 fe untouched by sm0 write", fe, 0);
    sm1 = 1'b1; sm2 = 1'b1; saddr = 8'h40; saden = 8'hF0;
    send_async(8'h4C, 1'b1, 1'b1, 1'b1, -1);
    check("R7 masked given hit ri", ri, 1);
    check("R5 byte", rx_byte, 8'h4C);
    check("R5 bit9", rx_bit9, 1);
    clear_ri();
    send_async(8'h4C, 1'b1, 1'b0, 1'b1, -1);
    check("R5 bit9 low blocks ri", ri, 0);
    send_async(8'h5C, 1'b1, 1'b1, 1'b1, -1);
    check("R7 given miss ri", ri, 0);
    check("R7 miss keeps buffer", rx_byte, 8'h4C);
    send_async(8'hF3, 1'b1, 1'b1, 1'b1, -1);
    check("R8 broadcast 9bit ri", ri, 1);
    check("R8 broadcast 9bit byte", rx_byte, 8'hF3);
    clear_ri();
    sm1 = 1'b0; sm2 = 1'b0;
    send_async(8'h12, 1'b1, 1'b0, 1'b1, -1);
    check("R5 sm2 off ri", ri, 1);
    check("R5 sm2 off byte", rx_byte, 8'h12);
    check("R5 sm2 off bit9", rx_bit9, 0);
    clear_ri();
  endtask

  task automatic t_shift();
    write_ctl7(1'b0, 1'b0);
    sm1 = 1'b0; sm2 = 1'b1; saddr = 8'h00; saden = 8'hFF;
    rx_en = 1'b1;
    for (int i = 0; i < 8; i++) bit_time(8'h96 >> i);
    rx_en = 1'b0;
    rxd = 1'b1;
    repeat (8) @(negedge clk);
    check("R11 shift ri with sm2 set", ri, 1);
    check("R11 shift byte", rx_byte, 8'h96);
    clear_ri();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    bit_time(1'b1);
    t_plain_8bit();
    t_glitch();
    t_false_start();
    t_framing();
    t_addr_8bit();
    t_addr_9bit();
    t_shift();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule